// File: doc/BRIEF.md
# Memory protection region checker

This block holds twelve address-range descriptors and decides, in the same cycle, whether a bus access may proceed. Each descriptor has a start address, an end address, a rights word and a valid flag. All four are set through a simple register write/read port. Every request carries a master number (0 to 7), an address, an access type and a privilege level. The block grants the request when at least one valid descriptor covers the address and permits that master, level and type. Otherwise it raises an error.

Masters come in two classes. Masters 0 to 3 have separate user and supervisor rights for read, write and execute. Masters 4 to 7 have only read and write enables, and these apply at every privilege level. Region ends are kept at 32-byte granularity. Any rewrite of a region's end address takes the region out of service until software sets its valid flag again.

Top module: `mpc_top`

## Requirements
- R1: Descriptor n (0 to 11) occupies configuration byte offsets n*16 + w*4. The region index sits in `cfg_addr_i[7:4]` and the word w in `cfg_addr_i[3:2]`. Word 0 is the start, word 1 the end, word 2 the rights and word 3 the valid flag in bit 0. Reads return the stored value. Indices 12 to 15 read as zero, and writes to them are ignored.
- R2: The start word stores address bits 31:5. Bits 4:0 read as zero, and a region begins at `{start[31:5],5'b0}`.
- R3: The end word stores address bits 31:5. Bits 4:0 always read as ones, so a region ends on the last byte of a 32-byte block. The end word resets to 0x0000001F.
- R4: Any write to a descriptor's end word clears its valid flag, and the region then matches nothing. Writing 1 to bit 0 of word 3 makes it valid again.
- R5: Nothing checks that the end is at least the start. A descriptor whose end is below its start matches no address.
- R6: After reset, every descriptor is invalid, its start is 0 and its rights are 0, so no access is granted.
- R7: Master m in 0 to 3 uses rights bits [5m+4:5m]. Within that field, bit 0 is user read, bit 1 user write, bit 2 user execute, and bits 4:3 are the supervisor code. Rights bits 31:28 read as zero.
- R8: For a supervisor access by masters 0 to 3, the supervisor code decides the rights. Code 00 grants read, write and execute. Code 01 grants read and execute. Code 10 grants read and write. Code 11 uses the user rights.
- R9: Master m in 4 to 7 uses rights bit 20+2(m-4) as read enable and the next bit as write enable, regardless of privilege. An instruction fetch is checked as a read.
- R10: An access is permitted when at least one valid covering region permits it. The rights of overlapping regions combine by OR.
- R11: The access type is encoded as 0 read, 1 write, 2 instruction fetch. Type 3 is never permitted.
- R12: The decision is combinational. `acc_grant_o` = `acc_valid_i` and permitted. `acc_err_o` = `acc_valid_i` and not permitted. Both are low when `acc_valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration byte offset |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data (combinational) |
| acc_valid_i | input | 1 | Access request present |
| acc_master_i | input | 3 | Requesting master number |
| acc_addr_i | input | 32 | Access address |
| acc_type_i | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| acc_super_i | input | 1 | Supervisor (1) or user (0) privilege |
| acc_grant_o | output | 1 | Access permitted |
| acc_err_o | output | 1 | Access refused |

## Verification
The bench uses the default of twelve regions. With that setting the highest descriptor (index 11) can be reached, and so can the unmapped indices 12 to 15 that the four-bit region field still encodes. Masters from both rights classes are driven, and all four supervisor codes are walked. The address tests probe one byte on each side of the start and end boundaries. They also cover regions with swapped bounds and two overlapping regions whose rights differ.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  localparam int ADDR_W   = 32;
  localparam int BLK_LSB  = 5;
  localparam int MST_W    = 3;
  localparam int N_FULL   = 4;
  localparam int FULL_W   = 5;
  localparam int N_RW     = 4;
  localparam int RW_BASE  = N_FULL * FULL_W;
  localparam int RIGHTS_W = RW_BASE + 2 * N_RW;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_type_e;

  typedef enum logic [1:0] {
    W_START  = 2'd0,
    W_END    = 2'd1,
    W_RIGHTS = 2'd2,
    W_VALID  = 2'd3
  } desc_word_e;
endpackage

// File: rtl/mpc_rights.sv
module mpc_rights
  import mpc_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [RIGHTS_W-1:0] rights_i,
  input  logic [MST_W-1:0]    master_i,
  input  logic [1:0]          type_i,
  input  logic                super_i,
  output logic                allow_o
);
  logic [FULL_W-1:0] full_f;
  logic [1:0]        rw_f;
  logic              r, w, x;

  assign full_f = rights_i[int'(master_i[1:0])*FULL_W +: FULL_W];
  assign rw_f   = rights_i[RW_BASE + int'(master_i[1:0])*2 +: 2];

  always_comb begin
    if (!master_i[2]) begin
      {x, w, r} = full_f[2:0];
      if (super_i) begin
        unique case (full_f[4:3])
          2'b00: {x, w, r} = 3'b111;
          2'b01: {x, w, r} = 3'b101;
          2'b10: {x, w, r} = 3'b011;
          default: {x, w, r} = full_f[2:0];
        endcase
      end
    end else begin
      r = rw_f[0];
      w = rw_f[1];
      x = rw_f[0]; // fetch checked as read
    end
  end

  always_comb begin
    unique case (acc_type_e'(type_i))
      ACC_READ:  allow_o = r;
      ACC_WRITE: allow_o = w;
      ACC_FETCH: allow_o = x;
      default:   allow_o = 1'b0;
    endcase
  end

  a_r11_rsvd_denied: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (type_i == 2'd3) |-> !allow_o);
  a_r9_rw_priv_blind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i[2] && type_i == 2'd1) |-> (allow_o == rights_i[RW_BASE + int'(master_i[1:0])*2 + 1]));
endmodule

// File: rtl/mpc_region.sv
module mpc_region
  import mpc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        word_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       rd_data_o,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [MST_W-1:0]  acc_master_i,
  input  logic [1:0]        acc_type_i,
  input  logic              acc_super_i,
  output logic              permit_o
);
  logic [ADDR_W-1:BLK_LSB] start_q, end_q;
  logic [RIGHTS_W-1:0]     rights_q;
  logic                    valid_q;
  logic                    hit, allow;
  logic                    unused_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q  <= '0;
      end_q    <= '0;
      rights_q <= '0;
      valid_q  <= 1'b0;
    end else if (wr_en_i) begin
      unique case (desc_word_e'(word_i))
        W_START:  start_q <= wr_data_i[ADDR_W-1:BLK_LSB];
        W_END: begin
          end_q   <= wr_data_i[ADDR_W-1:BLK_LSB];
          valid_q <= 1'b0;
        end
        W_RIGHTS: rights_q <= wr_data_i[RIGHTS_W-1:0];
        default:  valid_q  <= wr_data_i[0];
      endcase
    end
  end

  always_comb begin
    unique case (desc_word_e'(word_i))
      W_START:  rd_data_o = {start_q, {BLK_LSB{1'b0}}};
      W_END:    rd_data_o = {end_q, {BLK_LSB{1'b1}}};
      W_RIGHTS: rd_data_o = {{(32-RIGHTS_W){1'b0}}, rights_q};
      default:  rd_data_o = {31'b0, valid_q};
    endcase
  end

  assign unused_lo = ^acc_addr_i[BLK_LSB-1:0];
  assign hit = valid_q && (acc_addr_i[ADDR_W-1:BLK_LSB] >= start_q)
                       && (acc_addr_i[ADDR_W-1:BLK_LSB] <= end_q);

  mpc_rights u_rights (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rights_i (rights_q),
    .master_i (acc_master_i),
    .type_i   (acc_type_i),
    .super_i  (acc_super_i),
    .allow_o  (allow)
  );

  assign permit_o = hit && allow;

  a_r4_end_wr_invalidates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && word_i == 2'd1) |=> !valid_q);
  a_r4_valid_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && word_i == 2'd3 && wr_data_i[0]) |=> valid_q);
  a_r5_inverted_no_permit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_q < start_q) |-> !permit_o);
  a_r10_invalid_no_permit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> !permit_o);
endmodule

// File: rtl/mpc_top.sv
module mpc_top
  import mpc_pkg::*;
#(
  parameter int NUM_REGIONS = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              acc_valid_i,
  input  logic [MST_W-1:0]  acc_master_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [1:0]        acc_type_i,
  input  logic              acc_super_i,
  output logic              acc_grant_o,
  output logic              acc_err_o
);
  localparam int IDX_W = 4;

  logic [IDX_W-1:0]       idx;
  logic [1:0]             word;
  logic [NUM_REGIONS-1:0] permit;
  logic [31:0]            rd_data [NUM_REGIONS];
  logic                   unused_cfg;

  assign idx        = cfg_addr_i[7:4];
  assign word       = cfg_addr_i[3:2];
  assign unused_cfg = ^cfg_addr_i[1:0];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
    mpc_region u_rgn (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_en_i      (cfg_we_i && (idx == IDX_W'(g))),
      .word_i       (word),
      .wr_data_i    (cfg_wdata_i),
      .rd_data_o    (rd_data[g]),
      .acc_addr_i   (acc_addr_i),
      .acc_master_i (acc_master_i),
      .acc_type_i   (acc_type_i),
      .acc_super_i  (acc_super_i),
      .permit_o     (permit[g])
    );
  end

  always_comb begin
    cfg_rdata_o = '0;
    for (int r = 0; r < NUM_REGIONS; r++)
      if (idx == IDX_W'(r)) cfg_rdata_o = rd_data[r];
  end

  assign acc_grant_o = acc_valid_i && (|permit);
  assign acc_err_o   = acc_valid_i && !(|permit);

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> (!acc_grant_o && !acc_err_o));
  a_r12_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |-> (acc_grant_o != acc_err_o));
  a_r11_rsvd_never_granted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_type_i == 2'd3) |-> !acc_grant_o);
endmodule

// File: tb/mpc_top_tb.sv
module mpc_top_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        acc_valid_i = 1'b0;
  logic [2:0]  acc_master_i = '0;
  logic [31:0] acc_addr_i = '0;
  logic [1:0]  acc_type_i = '0;
  logic        acc_super_i = 1'b0;
  logic        acc_grant_o, acc_err_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  mpc_top u_dut (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int rg, input int wd, input logic [31:0] d);
    @(negedge clk_i);
    cfg_addr_i = {rg[3:0], wd[1:0], 2'b00};
    cfg_wdata_i = d;
    cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic rd(input int rg, input int wd, input logic [31:0] exp, input string tag);
    cfg_addr_i = {rg[3:0], wd[1:0], 2'b00};
    #1;
    chk(cfg_rdata_o, exp, tag);
  endtask

  // expect grant (g=1) or error (g=0)
  task automatic acc(input int m, input logic [31:0] a, input int t, input bit s,
                     input bit g, input string tag);
    acc_valid_i = 1'b1;
    acc_master_i = m[2:0];
    acc_addr_i = a;
    acc_type_i = t[1:0];
    acc_super_i = s;
    #1;
    chk({30'b0, acc_grant_o, acc_err_o}, {30'b0, g, !g}, tag);
    acc_valid_i = 1'b0;
  endtask

  task automatic define(input int rg, input logic [31:0] s, input logic [31:0] e,
                        input logic [31:0] rt);
    wr(rg, 0, s);
    wr(rg, 1, e);
    wr(rg, 2, rt);
    wr(rg, 3, 32'h1);
  endtask

  task automatic t_reset;
    rd(0, 1, 32'h0000_001F, "R3 end reset");
    rd(11, 1, 32'h0000_001F, "R3 end reset r11");
    rd(0, 3, 32'h0, "R6 valid reset");
    rd(5, 2, 32'h0, "R6 rights reset");
    acc(0, 32'h0, 0, 1'b1, 1'b0, "R6 no grant after reset");
    #1;
    chk({30'b0, acc_grant_o, acc_err_o}, 32'h0, "R12 idle quiet");
  endtask

  task automatic t_regs;
    wr(11, 0, 32'h1234_5678);
    rd(11, 0, 32'h1234_5660, "R2 start low zero");
    wr(11, 1, 32'h0000_2000);
    rd(11, 1, 32'h0000_201F, "R3 end low ones");
    wr(11, 2, 32'hFFFF_FFFF);
    rd(11, 2, 32'h0FFF_FFFF, "R7 rights top zero");
    wr(12, 3, 32'h1);
    rd(12, 3, 32'h0, "R1 unmapped index reads zero");
    rd(0, 3, 32'h0, "R1 unmapped write no effect");
    wr(11, 2, 32'h0);
  endtask

  task automatic t_range;
    define(0, 32'h0000_1000, 32'h0000_1FE0, 32'h0000_0003);
    rd(0, 3, 32'h1, "R4 valid set");
    acc(0, 32'h0000_0FFF, 0, 1'b0, 1'b0, "R2 below start");
    acc(0, 32'h0000_1000, 0, 1'b0, 1'b1, "R2 at start");
    acc(0, 32'h0000_1FFF, 1, 1'b0, 1'b1, "R3 last byte of end block");
    acc(0, 32'h0000_2000, 0, 1'b0, 1'b0, "R3 past end");
    acc(0, 32'h0000_1800, 2, 1'b0, 1'b0, "R7 user exec denied");
    acc(0, 32'h0000_1800, 3, 1'b1, 1'b0, "R11 reserved type");
    acc(1, 32'h0000_1800, 0, 1'b0, 1'b0, "R7 other master no rights");
  endtask

  task automatic t_invalidate;
    wr(0, 1, 32'h0000_1FE0);
    rd(0, 3, 32'h0, "R4 end write clears valid");
    acc(0, 32'h0000_1800, 0, 1'b0, 1'b0, "R4 no match after end write");
    wr(0, 3, 32'h1);
    acc(0, 32'h0000_1800, 0, 1'b0, 1'b1, "R4 match after revalidate");
  endtask

  task automatic t_super;
    // master 1 user read only; walk supervisor codes
    for (int c = 0; c < 4; c++) begin
      bit er, ew, ex;
      wr(1, 2, 32'(({c[1:0], 3'b001}) << 5));
      wr(1, 0, 32'h0001_0000);
      wr(1, 1, 32'h0001_FFFF);
      wr(1, 3, 32'h1);
      er = 1'b1;
      ew = (c == 0) || (c == 2);
      ex = (c == 0) || (c == 1);
      acc(1, 32'h0001_0100, 0, 1'b1, er, $sformatf("R8 code %0d read", c));
      acc(1, 32'h0001_0100, 1, 1'b1, ew, $sformatf("R8 code %0d write", c));
      acc(1, 32'h0001_0100, 2, 1'b1, ex, $sformatf("R8 code %0d fetch", c));
      acc(1, 32'h0001_0100, 1, 1'b0, 1'b0, $sformatf("R7 code %0d user write", c));
    end
  endtask

  task automatic t_rw_master;
    define(2, 32'h0002_0000, 32'h0002_0FE0, 32'h0040_0000); // master 5 read
    acc(5, 32'h0002_0010, 0, 1'b0, 1'b1, "R9 m5 read");
    acc(5, 32'h0002_0010, 2, 1'b1, 1'b1, "R9 m5 fetch as read");
    acc(5, 32'h0002_0010, 1, 1'b1, 1'b0, "R9 m5 write denied super");
    acc(4, 32'h0002_0010, 0, 1'b0, 1'b0, "R9 m4 no rights");
    wr(2, 2, 32'h0080_0000); // master 5 write only
    acc(5, 32'h0002_0010, 1, 1'b0, 1'b1, "R9 m5 write user");
    acc(5, 32'h0002_0010, 2, 1'b0, 1'b0, "R9 m5 fetch denied");
  endtask

  task automatic t_overlap;
    define(3, 32'h0003_0000, 32'h0003_0FE0, 32'h0000_0001); // m0 read
    define(4, 32'h0003_0800, 32'h0003_17E0, 32'h0000_0002); // m0 write
    acc(0, 32'h0003_0900, 0, 1'b0, 1'b1, "R10 overlap read");
    acc(0, 32'h0003_0900, 1, 1'b0, 1'b1, "R10 overlap write");
    acc(0, 32'h0003_0100, 1, 1'b0, 1'b0, "R10 only read region");
    acc(0, 32'h0003_1200, 0, 1'b0, 1'b0, "R10 only write region");
  endtask

  task automatic t_inverted;
    define(5, 32'h0005_0000, 32'h0004_0000, 32'h0000_0007);
    acc(0, 32'h0004_8000, 0, 1'b0, 1'b0, "R5 swapped bounds mid");
    acc(0, 32'h0005_0000, 0, 1'b0, 1'b0, "R5 swapped bounds at start");
    rd(5, 3, 32'h1, "R5 swapped still valid");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_regs();
    t_range();
    t_invalidate();
    t_super();
    t_rw_master();
    t_overlap();
    t_inverted();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule